// File: doc/BRIEF.md
# Single-Channel Memory Transfer Sequencer

This block sequences one memory-to-memory transfer channel inside a 16-bit byte-addressed memory space. Software hands it a decoded descriptor (source and destination start addresses, a maximum length, a length mode, item size, transfer mode, trigger select, separate step codes for the two addresses, an interrupt mask and a 7/8-bit selector) and pulses an arm input. The channel latches the descriptor, waits for its trigger, then moves items one at a time. Each item is a read from the source address followed by a write of the same data to the destination address, over a request/grant memory port.

The length of a run is either taken from the descriptor or derived from the first item read, plus an offset chosen by the length mode, limited by the descriptor length. Single modes move one item per trigger. Block modes move the whole run on one trigger. One-shot modes disarm when the run ends. Repeated modes stay armed and restart from the start addresses. Every completed run gives a done pulse, and an interrupt pulse as well when the mask bit is set. An abort strobe disarms the channel at once.

Top module: `dma_xfer_engine`

## Requirements
- R1: A pulse on arm_i while the channel is idle or armed and waiting latches the descriptor inputs, loads both start addresses, clears the item count and raises armed_o. No memory request is made until a trigger arrives. Later changes on the descriptor inputs have no effect until the next arm.
- R2: While the channel is armed and idle, sw_req_i always starts it. A trigger select of 0 accepts no hardware trigger. Select 1 accepts prev_done_i. Any select k of 2 or more accepts only trig_vec_i[k]. Triggers that arrive while a transfer is in flight are ignored.
- R3: Each item is one read request (mem_we_o=0) at the source address, then one write request (mem_we_o=1) at the destination address that carries the data returned by the read. mem_word_o is 1 for 16-bit items and 0 for bytes. A byte travels in bits 7:0.
- R4: Transfer mode tmode[1:0] uses these codes: 00 single, 01 block, 10 repeated single, 11 repeated block. In the single modes each trigger moves exactly one item. In the block modes one trigger moves the whole run back to back.
- R5: When the last item of a run is written, modes 00 and 01 drop armed_o. Modes 10 and 11 keep armed_o high and restart from the latched start addresses with a fresh count.
- R6: Length modes 000 and 111, and the reserved modes 101 and 110, use the 13-bit length field as the item count. A length of 0 moves one item.
- R7: In length modes 001, 010, 011 and 100 the count is n+1, n, n+2 and n+3 respectively. Here n is taken from the first item read. When n is greater than or equal to the length field, the count is the length field instead. A computed count of 0 moves one item, the first.
- R8: For byte items n is bits 7:0 of the first item when the 7-bit flag is 0, and bits 6:0 when it is 1. For 16-bit items n is bits 12:0 of the first item.
- R9: After each item, each address moves by its 2-bit step code: 00 no change, 01 plus one item, 10 plus two items, 11 minus one item. One item is 1 byte, or 2 bytes for 16-bit items. Addresses wrap at 16 bits.
- R10: On the cycle after the last write of a run is granted, done_o pulses for one cycle. irq_o pulses in that same cycle only when the interrupt mask bit is 1.
- R11: abort_i takes priority over every other input. It returns the channel to idle on the next edge (armed_o low), withdraws any request, and produces no done or interrupt pulse.
- R12: Once raised, a memory request holds its address, direction and write data unchanged until mem_gnt_i is seen high, unless an abort intervenes.
- R13: After reset the channel is idle, with armed_o, busy_o, mem_req_o, done_o and irq_o all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm / re-arm strobe, latches descriptor |
| abort_i | input | 1 | Abort strobe |
| sw_req_i | input | 1 | Software start request |
| prev_done_i | input | 1 | Completion pulse of the preceding channel |
| trig_vec_i | input | 32 | Hardware trigger lines indexed by select code |
| cfg_src_i | input | 16 | Source start address |
| cfg_dst_i | input | 16 | Destination start address |
| cfg_len_i | input | 13 | Length field (fixed count or limit) |
| cfg_lmode_i | input | 3 | Length mode |
| cfg_word_i | input | 1 | 1 = 16-bit items, 0 = bytes |
| cfg_tmode_i | input | 2 | Transfer mode |
| cfg_trig_i | input | 5 | Trigger select |
| cfg_sstep_i | input | 2 | Source step code |
| cfg_dstep_i | input | 2 | Destination step code |
| cfg_irq_en_i | input | 1 | Interrupt mask |
| cfg_low7_i | input | 1 | Use 7 bits of first byte for n |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_word_o | output | 1 | Item size of the request |
| mem_addr_o | output | 16 | Request byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid while a read is granted |
| mem_gnt_i | input | 1 | Grant for the current request |
| armed_o | output | 1 | Channel armed |
| busy_o | output | 1 | Item transfer in flight |
| done_o | output | 1 | Run-complete pulse |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The properties assume that the memory returns read data in the same cycle it grants a read, and that arm_i is not pulsed while an item is in flight. The bench memory model answers combinationally from its array and drives grants from a free-running pseudo-random pattern. Stimulus only ever pulses arm_i while busy_o is low. Source and destination regions are kept apart, so the expected memory image can be computed without regard to the order of reads and writes.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam int unsigned DMA_AW   = 16;
  localparam int unsigned DMA_DW   = 16;
  localparam int unsigned DMA_LW   = 13;
  localparam int unsigned DMA_CW   = DMA_LW + 1;
  localparam int unsigned DMA_TW   = 5;
  localparam int unsigned DMA_NTRG = 1 << DMA_TW;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RD    = 2'd2,
    ST_WR    = 2'd3
  } dma_st_e;

  typedef struct packed {
    logic [DMA_AW-1:0] src;
    logic [DMA_AW-1:0] dst;
    logic [DMA_LW-1:0] len;
    logic [2:0]        lmode;
    logic              word;
    logic [1:0]        tmode;
    logic [DMA_TW-1:0] trig;
    logic [1:0]        sstep;
    logic [1:0]        dstep;
    logic              irq_en;
    logic              low7;
  } dma_desc_t;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dma_count_calc.sv
module dma_count_calc
  import dma_eng_pkg::*;
(
  input  logic [2:0]        lmode_i,
  input  logic [DMA_LW-1:0] len_i,
  input  logic              word_i,
  input  logic              low7_i,
  input  logic [DMA_LW-1:0] first_i,
  output logic [DMA_CW-1:0] count_o
);
  logic [DMA_LW-1:0] n_val;
  logic [DMA_CW-1:0] offset;
  logic [DMA_CW-1:0] raw;
  logic              is_var;

  always_comb begin
    if (word_i)      n_val = first_i;
    else if (low7_i) n_val = DMA_LW'(first_i[6:0]);
    else             n_val = DMA_LW'(first_i[7:0]);
  end

  always_comb begin
    is_var = 1'b1;
    offset = '0;
    unique case (lmode_i)
      3'b001:  offset = DMA_CW'(1);
      3'b010:  offset = DMA_CW'(0);
      3'b011:  offset = DMA_CW'(2);
      3'b100:  offset = DMA_CW'(3);
      default: is_var = 1'b0;
    endcase
  end

  always_comb begin
    if (!is_var)             raw = DMA_CW'(len_i);
    else if (n_val >= len_i) raw = DMA_CW'(len_i);
    else                     raw = DMA_CW'(n_val) + offset;
    count_o = (raw == '0) ? DMA_CW'(1) : raw;
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_eng_pkg::*;
(
  input  logic [DMA_AW-1:0] cur_i,
  input  logic [1:0]        code_i,
  input  logic              word_i,
  output logic [DMA_AW-1:0] nxt_o
);
  logic [DMA_AW-1:0] unit;

  assign unit = word_i ? DMA_AW'(2) : DMA_AW'(1);

  always_comb begin
    unique case (code_i)
      2'b00: nxt_o = cur_i;
      2'b01: nxt_o = cur_i + unit;
      2'b10: nxt_o = cur_i + (unit << 1);
      2'b11: nxt_o = cur_i - unit;
    endcase
  end
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
  import dma_eng_pkg::*;
(
  input  logic [DMA_TW-1:0]   sel_i,
  input  logic [DMA_NTRG-1:0] vec_i,
  input  logic                prev_done_i,
  input  logic                sw_req_i,
  output logic                fire_o
);
  logic hw_hit;

  always_comb begin
    if (sel_i == DMA_TW'(0))      hw_hit = 1'b0;
    else if (sel_i == DMA_TW'(1)) hw_hit = prev_done_i;
    else                          hw_hit = vec_i[sel_i];
  end

  assign fire_o = sw_req_i | hw_hit;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_i,
  input  logic                abort_i,
  input  logic                sw_req_i,
  input  logic                prev_done_i,
  input  logic [DMA_NTRG-1:0] trig_vec_i,
  input  logic [DMA_AW-1:0]   cfg_src_i,
  input  logic [DMA_AW-1:0]   cfg_dst_i,
  input  logic [DMA_LW-1:0]   cfg_len_i,
  input  logic [2:0]          cfg_lmode_i,
  input  logic                cfg_word_i,
  input  logic [1:0]          cfg_tmode_i,
  input  logic [DMA_TW-1:0]   cfg_trig_i,
  input  logic [1:0]          cfg_sstep_i,
  input  logic [1:0]          cfg_dstep_i,
  input  logic                cfg_irq_en_i,
  input  logic                cfg_low7_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic                mem_word_o,
  output logic [DMA_AW-1:0]   mem_addr_o,
  output logic [DMA_DW-1:0]   mem_wdata_o,
  input  logic [DMA_DW-1:0]   mem_rdata_i,
  input  logic                mem_gnt_i,
  output logic                armed_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                irq_o
);
  localparam int unsigned NPTR = 2;

  logic rst_i_n;

  dma_st_e   st_q, st_n;
  dma_desc_t desc_q, desc_in;
  logic [DMA_AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [DMA_DW-1:0] data_q;
  logic [DMA_CW-1:0] cnt_q, cnt_n, tgt_q, tgt_n, cnt_inc, calc_cnt;
  logic              tknown_q, tknown_n;
  logic              done_q, done_n, irq_q, irq_n;
  logic              desc_en, data_en, fire, arm_take, last_item;

  logic [DMA_AW-1:0] ptr_cur [NPTR];
  logic [1:0]        ptr_code[NPTR];
  logic [DMA_AW-1:0] ptr_nxt [NPTR];

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign desc_in = '{src: cfg_src_i, dst: cfg_dst_i, len: cfg_len_i,
                     lmode: cfg_lmode_i, word: cfg_word_i, tmode: cfg_tmode_i,
                     trig: cfg_trig_i, sstep: cfg_sstep_i, dstep: cfg_dstep_i,
                     irq_en: cfg_irq_en_i, low7: cfg_low7_i};

  dma_trig_sel u_trig (
    .sel_i       (desc_q.trig),
    .vec_i       (trig_vec_i),
    .prev_done_i (prev_done_i),
    .sw_req_i    (sw_req_i),
    .fire_o      (fire)
  );

  dma_count_calc u_cnt (
    .lmode_i (desc_q.lmode),
    .len_i   (desc_q.len),
    .word_i  (desc_q.word),
    .low7_i  (desc_q.low7),
    .first_i (mem_rdata_i[DMA_LW-1:0]),
    .count_o (calc_cnt)
  );

  assign ptr_cur[0]  = src_q;
  assign ptr_cur[1]  = dst_q;
  assign ptr_code[0] = desc_q.sstep;
  assign ptr_code[1] = desc_q.dstep;

  for (genvar g = 0; g < NPTR; g++) begin : g_step
    dma_addr_step u_step (
      .cur_i  (ptr_cur[g]),
      .code_i (ptr_code[g]),
      .word_i (desc_q.word),
      .nxt_o  (ptr_nxt[g])
    );
  end

  assign arm_take  = arm_i && ((st_q == ST_IDLE) || (st_q == ST_ARMED));
  assign cnt_inc   = cnt_q + DMA_CW'(1);
  assign last_item = (cnt_inc >= tgt_q);
  assign desc_en   = arm_take && !abort_i;
  assign data_en   = (st_q == ST_RD) && mem_gnt_i && !abort_i;

  always_comb begin
    st_n     = st_q;
    src_n    = src_q;
    dst_n    = dst_q;
    cnt_n    = cnt_q;
    tgt_n    = tgt_q;
    tknown_n = tknown_q;
    done_n   = 1'b0;
    irq_n    = 1'b0;
    if (abort_i) begin
      st_n = ST_IDLE;
    end else if (arm_take) begin
      st_n     = ST_ARMED;
      src_n    = cfg_src_i;
      dst_n    = cfg_dst_i;
      cnt_n    = '0;
      tknown_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ARMED: if (fire) st_n = ST_RD;
        ST_RD: begin
          if (mem_gnt_i) begin
            if (!tknown_q) begin
              tgt_n    = calc_cnt;
              tknown_n = 1'b1;
            end
            st_n = ST_WR;
          end
        end
        ST_WR: begin
          if (mem_gnt_i) begin
            cnt_n = cnt_inc;
            src_n = ptr_nxt[0];
            dst_n = ptr_nxt[1];
            if (last_item) begin
              done_n = 1'b1;
              irq_n  = desc_q.irq_en;
              if (desc_q.tmode[1]) begin
                src_n    = desc_q.src;
                dst_n    = desc_q.dst;
                cnt_n    = '0;
                tknown_n = 1'b0;
                st_n     = ST_ARMED;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              st_n = desc_q.tmode[0] ? ST_RD : ST_ARMED;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q     <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      tgt_q    <= '0;
      tknown_q <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      st_q     <= st_n;
      src_q    <= src_n;
      dst_q    <= dst_n;
      cnt_q    <= cnt_n;
      tgt_q    <= tgt_n;
      tknown_q <= tknown_n;
      done_q   <= done_n;
      irq_q    <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     desc_q <= '0;
    else if (desc_en) desc_q <= desc_in;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     data_q <= '0;
    else if (data_en) data_q <= mem_rdata_i;
  end

  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_word_o  = desc_q.word;
  assign mem_addr_o  = (st_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata_o = desc_q.word ? data_q : {8'h00, data_q[7:0]};
  assign armed_o     = (st_q != ST_IDLE);
  assign busy_o      = mem_req_o;
  assign done_o      = done_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk
  import dma_eng_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DMA_AW-1:0] mem_addr_o,
  input logic [DMA_DW-1:0] mem_wdata_o,
  input logic              mem_gnt_i,
  input logic              armed_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              irq_o
);
  // R11
  a_r11_abort_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !armed_o && !mem_req_o);

  // R12
  a_r12_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i && !abort_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R10
  a_r10_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_o);

  // R10
  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_req_o && mem_we_o && mem_gnt_i && !abort_i));

  // R3
  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o && mem_gnt_i && !abort_i) |=> (mem_req_o && mem_we_o));

  // R13
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o |-> (!mem_req_o && !busy_o));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_i     (abort_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_gnt_i   (mem_gnt_i),
  .armed_o     (armed_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .irq_o       (irq_o)
);

// File: tb/sim_dma_xfer_engine.sv
module sim_dma_xfer_engine;
  localparam int CLK_P = 10;
  localparam int SRC0  = 'h080;
  localparam int DST0  = 'h280;

  logic        clk, rst_n;
  logic        arm, abort_s, sw_req, prev_done;
  logic [31:0] trig_vec;
  logic [15:0] c_src, c_dst;
  logic [12:0] c_len;
  logic [2:0]  c_lmode;
  logic        c_word, c_irq, c_low7;
  logic [1:0]  c_tmode, c_sstep, c_dstep;
  logic [4:0]  c_trig;
  logic        mem_req, mem_we, mem_word, mem_gnt, armed, busy, done, irq;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  logic [7:0]  mem   [0:1023];
  logic [7:0]  exp_m [0:1023];
  logic [7:0]  lfsr;
  logic        gnt_rand;
  int          wr_cnt, done_cnt, irq_cnt, first_wr;
  int          tests, fails;
  logic [7:0]  first_b;
  logic [15:0] first_w;

  dma_xfer_engine u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .abort_i(abort_s), .sw_req_i(sw_req),
    .prev_done_i(prev_done), .trig_vec_i(trig_vec),
    .cfg_src_i(c_src), .cfg_dst_i(c_dst), .cfg_len_i(c_len), .cfg_lmode_i(c_lmode),
    .cfg_word_i(c_word), .cfg_tmode_i(c_tmode), .cfg_trig_i(c_trig),
    .cfg_sstep_i(c_sstep), .cfg_dstep_i(c_dstep), .cfg_irq_en_i(c_irq), .cfg_low7_i(c_low7),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_word_o(mem_word), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_gnt_i(mem_gnt),
    .armed_o(armed), .busy_o(busy), .done_o(done), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    if (mem_word) mem_rdata = {mem[mem_addr[9:0]], mem[mem_addr[9:0] + 10'd1]};
    else          mem_rdata = {8'h00, mem[mem_addr[9:0]]};
  end

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_gnt) begin
      if (wr_cnt == 0) first_wr = int'(mem_addr);
      if (mem_word) begin
        mem[mem_addr[9:0]]         = mem_wdata[15:8];
        mem[mem_addr[9:0] + 10'd1] = mem_wdata[7:0];
      end else begin
        mem[mem_addr[9:0]] = mem_wdata[7:0];
      end
      wr_cnt++;
    end
    if (done) done_cnt++;
    if (irq)  irq_cnt++;
  end

  always @(negedge clk) begin
    if (!rst_n) lfsr <= 8'h5a;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt <= gnt_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clr_counts();
    wr_cnt = 0; done_cnt = 0; irq_cnt = 0; first_wr = -1;
  endtask

  task automatic setup_mem();
    for (int i = 0; i < 1024; i++) mem[i] = (i < 512) ? 8'(i * 37 + 11) : 8'hEE;
    if (c_word) begin
      mem[SRC0] = first_w[15:8]; mem[SRC0 + 1] = first_w[7:0];
    end else begin
      mem[SRC0] = first_b;
    end
  endtask

  function automatic int stride(input logic [1:0] code, input logic word);
    int u = word ? 2 : 1;
    case (code)
      2'b00: return 0;
      2'b01: return u;
      2'b10: return 2 * u;
      default: return -u;
    endcase
  endfunction

  function automatic int exp_count();
    int n, c;
    if (c_word)      n = int'(first_w[12:0]);
    else if (c_low7) n = int'(first_b[6:0]);
    else             n = int'(first_b);
    case (c_lmode)
      3'd1: c = (n >= c_len) ? int'(c_len) : n + 1;
      3'd2: c = (n >= c_len) ? int'(c_len) : n;
      3'd3: c = (n >= c_len) ? int'(c_len) : n + 2;
      3'd4: c = (n >= c_len) ? int'(c_len) : n + 3;
      default: c = int'(c_len);
    endcase
    return (c == 0) ? 1 : c;
  endfunction

  task automatic build_exp(input int cnt);
    int s = SRC0, d = DST0;
    for (int i = 0; i < 1024; i++) exp_m[i] = mem[i];
    for (int i = 0; i < cnt; i++) begin
      exp_m[d & 1023] = exp_m[s & 1023];
      if (c_word) exp_m[(d + 1) & 1023] = exp_m[(s + 1) & 1023];
      s += stride(c_sstep, c_word);
      d += stride(c_dstep, c_word);
    end
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic pulse_sw();
    sw_req = 1'b1;
    @(negedge clk); sw_req = 1'b0;
  endtask

  task automatic wait_wr(input int target);
    int t = 0;
    while (wr_cnt < target && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic do_abort();
    @(negedge clk); abort_s = 1'b1;
    @(negedge clk); abort_s = 1'b0;
  endtask

  // Full run of the current configuration; checks tagged with req
  task automatic run_cfg(input string req);
    int ecnt, bad;
    setup_mem();
    ecnt = exp_count();
    build_exp(ecnt);
    c_src = 16'(SRC0); c_dst = 16'(DST0); c_trig = 5'd0;
    clr_counts();
    pulse_arm();
    if (c_tmode[0]) begin
      pulse_sw();
      wait_wr(ecnt);
    end else begin
      for (int k = 0; k < ecnt; k++) begin
        int t = 0;
        while (busy && t < 100) begin @(negedge clk); t++; end
        pulse_sw();
        wait_wr(k + 1);
        repeat (3) @(negedge clk);
        // R4: one item per trigger in single modes
        if (k == 0) chk(wr_cnt == 1, "R4", "items after first trigger", wr_cnt, 1);
      end
    end
    repeat (6) @(negedge clk);
    chk(wr_cnt == ecnt, req, "item count", wr_cnt, ecnt);
    bad = 0;
    for (int i = 512; i < 1024; i++) if (mem[i] !== exp_m[i]) bad++;
    chk(bad == 0, "R3/R9", "dest bytes mismatched", bad, 0);
    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    chk(irq_cnt == int'(c_irq), "R10", "irq pulses", irq_cnt, int'(c_irq));
    chk(armed == c_tmode[1], "R5", "armed after run", int'(armed), int'(c_tmode[1]));
    if (c_tmode[1]) begin
      clr_counts();
      pulse_sw();
      wait_wr(1);
      chk(first_wr == DST0, "R5", "restart dest address", first_wr, DST0);
      repeat (ecnt * 12 + 10) @(negedge clk);
      do_abort();
      chk(!armed, "R11", "armed after abort", int'(armed), 0);
    end
  endtask

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; arm = 0; abort_s = 0; sw_req = 0; prev_done = 0; trig_vec = '0;
    c_src = 0; c_dst = 0; c_len = 0; c_lmode = 0; c_word = 0; c_tmode = 0; c_trig = 0;
    c_sstep = 2'b01; c_dstep = 2'b01; c_irq = 0; c_low7 = 0; gnt_rand = 0;
    first_b = 8'h00; first_w = 16'h0000;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    clr_counts();
    repeat (3) @(negedge clk);
    chk(!armed && !busy && !mem_req && !done && !irq, "R13", "outputs in reset", int'(armed | mem_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!armed && !mem_req && !done, "R13", "outputs after reset", int'(armed | mem_req | done), 0);
    gnt_rand = 1'b1;

    // Length-mode sweep: all codes, byte 8/7-bit and word n
    c_len = 13'd6; c_tmode = 2'b01;
    first_b = 8'h83; first_w = 16'hE003;
    for (int lm = 0; lm < 8; lm++)
      for (int w = 0; w < 2; w++)
        for (int l7 = 0; l7 < 2; l7++) begin
          c_lmode = 3'(lm); c_word = w[0]; c_low7 = l7[0]; c_irq = l7[0];
          run_cfg((lm >= 1 && lm <= 4) ? (w != 0 ? "R7/R8 word" : "R7/R8 byte") : "R6");
        end

    // n equal to the limit, n of zero, length of zero
    c_word = 0; c_low7 = 0; c_lmode = 3'd1; first_b = 8'h06; run_cfg("R7 n==len clamp");
    c_low7 = 1; c_lmode = 3'd2; first_b = 8'h80; run_cfg("R7 zero count");
    c_low7 = 0; c_lmode = 3'd0; c_len = 13'd0; run_cfg("R6 zero length");
    c_lmode = 3'd5; c_len = 13'd4; run_cfg("R6 reserved mode");

    // Step code sweep
    c_lmode = 3'd0; c_len = 13'd5; c_irq = 0;
    for (int w = 0; w < 2; w++)
      for (int ss = 0; ss < 4; ss++)
        for (int ds = 0; ds < 4; ds++) begin
          c_word = w[0]; c_sstep = 2'(ss); c_dstep = 2'(ds);
          run_cfg("R9");
        end
    c_sstep = 2'b01; c_dstep = 2'b01;

    // Transfer modes with and without interrupt mask
    c_len = 13'd4; c_word = 0;
    for (int tm = 0; tm < 4; tm++)
      for (int ie = 0; ie < 2; ie++) begin
        c_tmode = 2'(tm); c_irq = ie[0];
        run_cfg("R4/R5");
      end

    // R1: arm without trigger moves nothing, re-arm reloads addresses
    c_tmode = 2'b01; c_lmode = 3'd0; c_len = 13'd3; c_irq = 0;
    setup_mem(); clr_counts();
    c_trig = 5'd0; c_src = 16'(SRC0); c_dst = 16'h0300;
    pulse_arm();
    c_dst = 16'h0340;
    repeat (20) @(negedge clk);
    chk(wr_cnt == 0 && armed, "R1", "writes while armed untriggered", wr_cnt, 0);
    c_dst = 16'h0320;
    pulse_arm();
    c_dst = 16'h0360;
    pulse_sw(); wait_wr(3); repeat (6) @(negedge clk);
    chk(first_wr == 'h320, "R1", "dest after re-arm", first_wr, 'h320);

    // R2: trigger select
    setup_mem(); clr_counts(); c_trig = 5'd0; c_dst = 16'(DST0);
    pulse_arm();
    trig_vec = '1; prev_done = 1'b1;
    repeat (10) @(negedge clk);
    trig_vec = '0; prev_done = 1'b0;
    chk(wr_cnt == 0 && armed, "R2", "select 0 hardware trigger writes", wr_cnt, 0);
    pulse_sw(); wait_wr(3); repeat (6) @(negedge clk);
    chk(wr_cnt == 3, "R2", "select 0 software start", wr_cnt, 3);

    clr_counts(); c_trig = 5'd1;
    pulse_arm();
    trig_vec = 32'h0000_0002;
    repeat (5) @(negedge clk);
    trig_vec = '0;
    chk(wr_cnt == 0, "R2", "select 1 ignores vector bit 1", wr_cnt, 0);
    prev_done = 1'b1; @(negedge clk); prev_done = 1'b0;
    wait_wr(3); repeat (6) @(negedge clk);
    chk(wr_cnt == 3 && done_cnt == 1, "R2", "select 1 previous-done start", wr_cnt, 3);

    clr_counts(); c_trig = 5'd9;
    pulse_arm();
    trig_vec = 32'h0000_0100; prev_done = 1'b1;
    repeat (5) @(negedge clk);
    trig_vec = '0; prev_done = 1'b0;
    chk(wr_cnt == 0, "R2", "select 9 ignores other lines", wr_cnt, 0);
    trig_vec = 32'h0000_0200; @(negedge clk); trig_vec = '0;
    wait_wr(3); repeat (6) @(negedge clk);
    chk(wr_cnt == 3, "R2", "select 9 line start", wr_cnt, 3);

    // R11: abort mid-block
    begin
      int w_at;
      setup_mem(); clr_counts(); c_trig = 5'd0; c_len = 13'd12; c_irq = 1'b1;
      pulse_arm();
      pulse_sw();
      wait_wr(3);
      do_abort();
      w_at = wr_cnt;
      chk(!armed && !mem_req, "R11", "armed/request after abort", int'(armed | mem_req), 0);
      repeat (30) @(negedge clk);
      chk(wr_cnt == w_at && wr_cnt < 12, "R11", "writes after abort", wr_cnt, w_at);
      chk(done_cnt == 0 && irq_cnt == 0, "R11", "completion pulses after abort", done_cnt + irq_cnt, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule